// File: doc/BRIEF.md
# Sliding Register Window with Special-Function Registers

This block sits between a small 8-bit core and its data memory. It decodes one byte/word access per clock. The sixteen lowest addresses form a window of working registers. The window is held in a larger internal register RAM. A pointer register selects the window's position in that RAM, so software can switch register banks by rewriting one byte. The next sixteen addresses hold the special-function registers, which include interrupt enables and requests, system and clock control, the stack pointer bytes, the window pointer, the status byte and four port latches.

Every write that lands in the window is also sent to the external memory port at the unmodified address, so the external image of the lowest sixteen bytes follows the active window. Accesses above the register area go straight to the external port. Word accesses are big-endian and may straddle regions: each of the two bytes is routed on its own.

Top module: `regwin_top`

## Requirements
- R1: A byte access at address 0x00–0x0F reaches register RAM index (pointer & 0xF8) + address, where the pointer is the SFR at 0x1E; data written there reads back from the same address while the pointer is unchanged.
- R2: A write to the pointer (0x1E) moves the window from the next cycle on; bytes stored under the old base keep their values and reappear when the old pointer value is restored.
- R3: The register RAM holds 264 bytes, so a pointer of 0xF8–0xFF places the window on indices 0xF8–0x107 without wrapping onto indices 0x00–0x0F.
- R4: A write that lands in the window also drives the external port in the same cycle at the unmodified address: ext_we[1] marks the byte at ext_addr carried on ext_wdata[15:8], and ext_we[0] marks the byte at ext_addr+1 carried on ext_wdata[7:0].
- R5: Addresses 0x10–0x1F are served internally and never raise ext_we or ext_re; 0x18 and 0x1B are unimplemented, read as 0x00 and ignore writes.
- R6: After reset the SFRs read 0x00, except 0x14, 0x15 and 0x16, which read 0xFF.
- R7: With bus_word high, the byte at the address travels on bits 15:8 and the byte at address+1 on bits 7:0, for both reads and writes.
- R8: Only bits 15:0 of bus_addr are decoded; higher bits have no effect on which location is reached.
- R9: Bytes at 0x20 and above are external: a write raises the matching ext_we bit, and a read raises the matching ext_re bit and returns ext_rdata[15:8] (byte at ext_addr) or ext_rdata[7:0] (byte at ext_addr+1).
- R10: The two bytes of a word access are routed independently, address+1 wraps from 0xFFFF to 0x0000, and both bytes of a window word use the pointer value held before the access.
- R11: A byte read returns its data on bits 7:0 with bits 15:8 zero, and bus_rdata is zero whenever bus_rd is low; reads are combinational in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | BUS_AW | Access address; only the low AW bits are decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 1 | Word access (two bytes, big-endian) |
| bus_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| bus_rdata | output | 16 | Read data, combinational |
| ext_addr | output | AW | External address of the first byte |
| ext_we | output | 2 | External byte write enables (bit 1: ext_addr, bit 0: ext_addr+1) |
| ext_re | output | 2 | External byte read enables (same lane order) |
| ext_wdata | output | 16 | External write data by lane |
| ext_rdata | input | 16 | External read data by lane |

## Verification
The bench builds the block with BUS_AW=20 and AW=16, so the address bus has four bits that must be ignored, and the truncation case can be written at one alias and read at another. It keeps WIN_SIZE=16 and BASE_ALIGN=8, which gives the 264-byte register RAM and makes the topmost window (pointer 0xFF) reachable. With those values the bench can show that the upper window does not wrap onto the bottom indices. A 16-bit address also lets a word at 0xFFFF carry its second byte into the window at 0x0000.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [1:0] {
    RGN_WIN = 2'd0,
    RGN_SFR = 2'd1,
    RGN_EXT = 2'd2
  } rgn_e;

  localparam int SFR_COUNT = 16;
  localparam logic [3:0] SFR_OFS_PTR  = 4'hE;
  localparam logic [3:0] SFR_OFS_HOLE_A = 4'h8;
  localparam logic [3:0] SFR_OFS_HOLE_B = 4'hB;

  // Power-on contents: port latches 0..2 idle high, everything else low.
  function automatic logic [7:0] sfr_reset(input logic [3:0] ofs);
    case (ofs)
      4'h4, 4'h5, 4'h6: return 8'hFF;
      default:          return 8'h00;
    endcase
  endfunction

  function automatic logic sfr_present(input logic [3:0] ofs);
    return (ofs != SFR_OFS_HOLE_A) && (ofs != SFR_OFS_HOLE_B);
  endfunction

endpackage

// File: rtl/regwin_lane.sv
module regwin_lane
  import regwin_pkg::*;
#(
  parameter int AW         = 16,
  parameter int WIN_SIZE   = 16,
  parameter int BASE_ALIGN = 8,
  parameter int IDX_W      = 9,
  parameter int BANK_AW    = 8
) (
  input  logic [AW-1:0]      addr,
  input  logic [7:0]         win_ptr,
  output rgn_e               rgn,
  output logic [BANK_AW-1:0] bank_idx
);
  localparam int OFF_W = $clog2(WIN_SIZE);
  localparam logic [7:0] ALIGN_MASK = ~8'(BASE_ALIGN - 1);

  logic [IDX_W-1:0] idx;

  always_comb begin
    if (addr < AW'(WIN_SIZE))
      rgn = RGN_WIN;
    else if (addr < AW'(WIN_SIZE + SFR_COUNT))
      rgn = RGN_SFR;
    else
      rgn = RGN_EXT;
  end

  assign idx      = IDX_W'(win_ptr & ALIGN_MASK) + IDX_W'(addr[OFF_W-1:0]);
  assign bank_idx = BANK_AW'(idx >> 1);

endmodule

// File: rtl/regwin_bank.sv
module regwin_bank #(
  parameter int DEPTH = 132,
  parameter int BAW   = 8
) (
  input  logic           clk,
  input  logic           we,
  input  logic [BAW-1:0] addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/regwin_sfr.sv
module regwin_sfr
  import regwin_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      we,
  input  logic [1:0][3:0] ofs,
  input  logic [1:0][7:0] wd,
  output logic [1:0][7:0] rd,
  output logic [7:0]      win_ptr
);
  logic [7:0] regs [SFR_COUNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SFR_COUNT; i++) regs[i] <= sfr_reset(4'(i));
    end else begin
      for (int l = 0; l < 2; l++) begin
        if (we[l] && sfr_present(ofs[l])) regs[ofs[l]] <= wd[l];
      end
    end
  end

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      rd[l] = sfr_present(ofs[l]) ? regs[ofs[l]] : 8'h00;
    end
  end

  assign win_ptr = regs[SFR_OFS_PTR];

endmodule

// File: rtl/regwin_top.sv
module regwin_top
  import regwin_pkg::*;
#(
  parameter int BUS_AW     = 20,
  parameter int AW         = 16,
  parameter int WIN_SIZE   = 16,
  parameter int BASE_ALIGN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_word,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [AW-1:0]     ext_addr,
  output logic [1:0]        ext_we,
  output logic [1:0]        ext_re,
  output logic [15:0]       ext_wdata,
  input  logic [15:0]       ext_rdata
);
  localparam int RAM_DEPTH  = 256 - BASE_ALIGN + WIN_SIZE;
  localparam int IDX_W      = $clog2(RAM_DEPTH);
  localparam int BANK_DEPTH = RAM_DEPTH / 2;
  localparam int BANK_AW    = IDX_W - 1;

  // Lane 0: byte at the address. Lane 1: byte at address+1 (word only).
  logic [1:0][AW-1:0]      lane_addr;
  logic [1:0]              lane_act;
  logic [1:0]              lane_we;
  logic [1:0][7:0]         lane_wd;
  logic [1:0][7:0]         lane_rd;
  rgn_e                    lane_rgn [2];
  logic [1:0][BANK_AW-1:0] lane_bidx;

  logic [1:0][7:0]         bank_rd;
  logic [1:0][7:0]         sfr_rd;
  logic [1:0]              sfr_we;
  logic [1:0][3:0]         sfr_ofs;
  logic [7:0]              win_ptr;
  logic                    unused_addr_hi;

  assign unused_addr_hi = ^bus_addr[BUS_AW-1:AW];

  assign lane_addr[0] = bus_addr[AW-1:0];
  assign lane_addr[1] = bus_addr[AW-1:0] + AW'(1);
  assign lane_act     = {bus_word, 1'b1};
  assign lane_we      = lane_act & {2{bus_wr}};
  assign lane_wd[0]   = bus_word ? bus_wdata[15:8] : bus_wdata[7:0];
  assign lane_wd[1]   = bus_wdata[7:0];

  for (genvar l = 0; l < 2; l++) begin : g_lane
    regwin_lane #(
      .AW(AW), .WIN_SIZE(WIN_SIZE), .BASE_ALIGN(BASE_ALIGN),
      .IDX_W(IDX_W), .BANK_AW(BANK_AW)
    ) u_lane (
      .addr     (lane_addr[l]),
      .win_ptr  (win_ptr),
      .rgn      (lane_rgn[l]),
      .bank_idx (lane_bidx[l])
    );

    assign sfr_we[l]  = lane_we[l] && (lane_rgn[l] == RGN_SFR);
    assign sfr_ofs[l] = 4'(lane_addr[l] - AW'(WIN_SIZE));
  end

  // Even bank holds even indices, odd bank odd ones. The window base is
  // aligned, so index parity equals address parity and the two bytes of a
  // word always fall in different banks.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic sel;
    logic we;
    assign sel = (lane_addr[0][0] != 1'(b));
    assign we  = lane_we[sel] && (lane_rgn[sel] == RGN_WIN);

    regwin_bank #(.DEPTH(BANK_DEPTH), .BAW(BANK_AW)) u_bank (
      .clk   (clk),
      .we    (we),
      .addr  (lane_bidx[sel]),
      .wdata (lane_wd[sel]),
      .rdata (bank_rd[b])
    );
  end

  regwin_sfr u_sfr (
    .clk     (clk),
    .rst     (rst),
    .we      (sfr_we),
    .ofs     (sfr_ofs),
    .wd      (lane_wd),
    .rd      (sfr_rd),
    .win_ptr (win_ptr)
  );

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      case (lane_rgn[l])
        RGN_WIN: lane_rd[l] = bank_rd[lane_addr[l][0]];
        RGN_SFR: lane_rd[l] = sfr_rd[l];
        default: lane_rd[l] = (l == 0) ? ext_rdata[15:8] : ext_rdata[7:0];
      endcase
    end
  end

  always_comb begin
    if (!bus_rd)       bus_rdata = 16'h0000;
    else if (bus_word) bus_rdata = {lane_rd[0], lane_rd[1]};
    else               bus_rdata = {8'h00, lane_rd[0]};
  end

  assign ext_addr  = lane_addr[0];
  assign ext_wdata = {lane_wd[0], lane_wd[1]};
  assign ext_we[1] = lane_we[0] && (lane_rgn[0] != RGN_SFR);
  assign ext_we[0] = lane_we[1] && (lane_rgn[1] != RGN_SFR);
  assign ext_re[1] = bus_rd && lane_act[0] && (lane_rgn[0] == RGN_EXT);
  assign ext_re[0] = bus_rd && lane_act[1] && (lane_rgn[1] == RGN_EXT);

endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          bus_word,
  input logic [7:0]    rdata_hi,
  input logic [1:0]    ext_we,
  input logic [1:0]    ext_re,
  input logic [7:0]    win_ptr
);
  localparam logic [AW-1:0] A_SFR_LO = AW'(16);
  localparam logic [AW-1:0] A_EXT_LO = AW'(32);
  localparam logic [AW-1:0] A_PTR    = AW'(8'h1E);
  localparam logic [AW-1:0] A_PTR_M1 = AW'(8'h1D);

  AST_WIN_MIRROR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_word && bus_addr < A_SFR_LO) |-> (ext_we == 2'b10)); // R4

  AST_SFR_LOCAL: assert property (@(posedge clk) disable iff (rst)
    ((bus_wr || bus_rd) && !bus_word && bus_addr >= A_SFR_LO && bus_addr < A_EXT_LO)
      |-> (ext_we == 2'b00 && ext_re == 2'b00)); // R5

  AST_EXT_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_word && bus_addr >= A_EXT_LO) |-> (ext_re == 2'b10)); // R9

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && (bus_addr == A_PTR || (bus_word && bus_addr == A_PTR_M1)))
      |=> $stable(win_ptr)); // R2

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!bus_word || !bus_rd) |-> (rdata_hi == 8'h00)); // R11

endmodule

bind regwin_top regwin_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr[AW-1:0]),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_word (bus_word),
  .rdata_hi (bus_rdata[15:8]),
  .ext_we   (ext_we),
  .ext_re   (ext_re),
  .win_ptr  (win_ptr)
);

// File: tb/regwin_top_tb.sv
module regwin_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_AW     = 20;
  localparam int AW         = 16;
  localparam int WD_CYCLES  = 5000;

  logic              clk = 1'b0;
  logic              rst;
  logic [BUS_AW-1:0] bus_addr;
  logic              bus_wr, bus_rd, bus_word;
  logic [15:0]       bus_wdata, bus_rdata;
  logic [AW-1:0]     ext_addr;
  logic [1:0]        ext_we, ext_re;
  logic [15:0]       ext_wdata, ext_rdata;

  int total = 0;
  int bad   = 0;

  // Reference model state
  logic [7:0] m_ram   [264];
  bit         m_known [264];
  logic [7:0] m_sfr   [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  // External memory image: a fixed function of the byte address
  assign ext_rdata = {ext_addr[7:0] ^ 8'h5A, (ext_addr[7:0] + 8'h01) ^ 8'h5A};

  regwin_top #(.BUS_AW(BUS_AW), .AW(AW), .WIN_SIZE(16), .BASE_ALIGN(8)) u_dut (
    .clk, .rst, .bus_addr, .bus_wr, .bus_rd, .bus_word, .bus_wdata, .bus_rdata,
    .ext_addr, .ext_we, .ext_re, .ext_wdata, .ext_rdata
  );

  function automatic int region(int x);
    if (x < 16) return 0;
    if (x < 32) return 1;
    return 2;
  endfunction

  function automatic int widx(int x);
    return int'(m_sfr[14] & 8'hF8) + (x & 15);
  endfunction

  function automatic bit has_sfr(int x);
    return !(x == 8'h18 || x == 8'h1B);
  endfunction

  function automatic logic [7:0] model_rd(int x, output bit known);
    known = 1'b1;
    case (region(x))
      0: begin known = m_known[widx(x)]; return m_ram[widx(x)]; end
      1: return has_sfr(x) ? m_sfr[x-16] : 8'h00;
      default: return 8'(x) ^ 8'h5A;
    endcase
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_sfr[i] = 8'h00;
    m_sfr[4] = 8'hFF; m_sfr[5] = 8'hFF; m_sfr[6] = 8'hFF;
  endtask

  task automatic do_op(bit wr, bit rd, bit word, logic [BUS_AW-1:0] addr,
                       logic [15:0] wd, string req);
    int a, a1, i0, i1;
    logic [7:0] d0, d1, b0, b1;
    bit k0, k1;
    logic [1:0] exp_we, exp_re;
    logic [15:0] mask, exp_rd;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_word = word; bus_addr = addr; bus_wdata = wd;
    a  = int'(addr[15:0]);
    a1 = (a + 1) & 16'hFFFF;
    d0 = word ? wd[15:8] : wd[7:0];
    d1 = wd[7:0];
    exp_we = {wr && region(a) != 1, wr && word && region(a1) != 1};
    exp_re = {rd && region(a) == 2, rd && word && region(a1) == 2};
    #2;
    check(req, "ext_we", {14'h0, ext_we}, {14'h0, exp_we});
    check(req, "ext_re", {14'h0, ext_re}, {14'h0, exp_re});
    if (wr) begin
      check(req, "ext_addr", ext_addr, 16'(a));
      mask = {{8{exp_we[1]}}, {8{exp_we[0]}}};
      check(req, "ext_wdata", ext_wdata & mask, {d0, d1} & mask);
    end
    b0 = model_rd(a, k0);
    b1 = model_rd(a1, k1);
    if (!rd) check(req, "rdata idle", bus_rdata, 16'h0000);
    else if (word && k0 && k1) check(req, "rdata word", bus_rdata, {b0, b1});
    else if (!word && k0) check(req, "rdata byte", bus_rdata, {8'h00, b0});
    i0 = widx(a);
    i1 = widx(a1);
    @(posedge clk);
    if (wr) begin
      if (region(a) == 0) begin m_ram[i0] = d0; m_known[i0] = 1'b1; end
      else if (region(a) == 1 && has_sfr(a)) m_sfr[a-16] = d0;
      if (word) begin
        if (region(a1) == 0) begin m_ram[i1] = d1; m_known[i1] = 1'b1; end
        else if (region(a1) == 1 && has_sfr(a1)) m_sfr[a1-16] = d1;
      end
    end
  endtask

  task automatic set_ptr(logic [7:0] p, string req);
    do_op(1, 0, 0, 20'h0001E, {8'h00, p}, req);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 264; i++) m_known[i] = 1'b0;
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_word = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 1'b0;

    // R6 / R5 / R11: reset contents of every SFR slot
    for (int x = 16; x < 32; x++) do_op(0, 1, 0, BUS_AW'(x), 16'h0, "R6");

    // R1 / R4: fill window at base 0 and read it back
    for (int i = 0; i < 16; i++) do_op(1, 0, 0, BUS_AW'(i), {8'h00, 8'(8'h40 + i)}, "R4");
    for (int i = 0; i < 16; i++) do_op(0, 1, 0, BUS_AW'(i), 16'h0, "R1");

    // R7: big-endian word
    do_op(1, 0, 1, 20'h00004, 16'hBEEF, "R7");
    do_op(0, 1, 1, 20'h00004, 16'h0, "R7");
    do_op(0, 1, 0, 20'h00005, 16'h0, "R7");

    // R2: move window, new data, restore, old data intact
    set_ptr(8'h13, "R2");
    for (int i = 0; i < 16; i++) do_op(1, 0, 0, BUS_AW'(i), {8'h00, 8'(8'h80 + i)}, "R2");
    for (int i = 0; i < 16; i++) do_op(0, 1, 0, BUS_AW'(i), 16'h0, "R2");
    set_ptr(8'h00, "R2");
    for (int i = 0; i < 16; i++) do_op(0, 1, 0, BUS_AW'(i), 16'h0, "R2");

    // R3: top window does not wrap onto the bottom indices
    set_ptr(8'hFF, "R3");
    for (int i = 0; i < 16; i++) do_op(1, 0, 0, BUS_AW'(i), {8'h00, 8'(8'hC0 + i)}, "R3");
    for (int i = 0; i < 16; i++) do_op(0, 1, 0, BUS_AW'(i), 16'h0, "R3");
    set_ptr(8'h00, "R3");
    for (int i = 0; i < 16; i++) do_op(0, 1, 0, BUS_AW'(i), 16'h0, "R3");
    set_ptr(8'h10, "R3");
    for (int i = 0; i < 16; i++) do_op(0, 1, 0, BUS_AW'(i), 16'h0, "R3");
    set_ptr(8'h00, "R3");

    // R5: holes ignore writes, a real SFR takes one
    do_op(1, 0, 0, 20'h00018, 16'h0077, "R5");
    do_op(1, 0, 0, 20'h0001B, 16'h0077, "R5");
    do_op(1, 0, 0, 20'h00011, 16'h003C, "R5");
    do_op(0, 1, 0, 20'h00018, 16'h0, "R5");
    do_op(0, 1, 0, 20'h0001B, 16'h0, "R5");
    do_op(0, 1, 0, 20'h00011, 16'h0, "R5");

    // R9: external region
    do_op(1, 0, 0, 20'h00123, 16'h0099, "R9");
    do_op(0, 1, 0, 20'h00123, 16'h0, "R9");
    do_op(0, 1, 1, 20'h07FFE, 16'h0, "R9");
    do_op(1, 0, 1, 20'h00020, 16'h1357, "R9");

    // R10: straddling words and address wrap
    do_op(1, 0, 1, 20'h0FFFF, 16'h1122, "R10");
    do_op(0, 1, 0, 20'h00000, 16'h0, "R10");
    do_op(0, 1, 1, 20'h0FFFF, 16'h0, "R10");
    do_op(1, 0, 1, 20'h0000F, 16'h5AA5, "R10");
    do_op(0, 1, 1, 20'h0000F, 16'h0, "R10");
    do_op(1, 0, 1, 20'h0001D, 16'hAB30, "R10");
    do_op(0, 1, 1, 20'h0001D, 16'h0, "R10");
    do_op(1, 0, 0, 20'h00002, 16'h00D2, "R10");
    do_op(0, 1, 0, 20'h00002, 16'h0, "R10");
    do_op(1, 0, 1, 20'h0001F, 16'h6677, "R10");
    set_ptr(8'h00, "R10");
    do_op(0, 1, 0, 20'h00002, 16'h0, "R10");

    // R8: upper address bits ignored
    do_op(1, 0, 0, 20'h50003, 16'h00E7, "R8");
    do_op(0, 1, 0, 20'hA0003, 16'h0, "R8");
    do_op(0, 1, 0, 20'h00003, 16'h0, "R8");
    do_op(0, 1, 0, 20'hF0015, 16'h0, "R8");

    // R11: idle cycle, read data zero
    do_op(0, 0, 0, 20'h00005, 16'hFFFF, "R11");
    do_op(0, 0, 1, 20'h00040, 16'hFFFF, "R11");

    summary();
    $finish;
  end

endmodule